// File: doc/BRIEF.md
# Lockstep Timing Leak Monitor

This block watches two copies of a processor core that run side by side from one clock and one reset. The two copies are fed identical programs and differ only in their secret data. The monitor counts the cycles each copy takes until it stores to its host-communication flag. Once both copies have finished, it declares a timing leak if the two cycle counts differ.

Independently of the leak decision, it compares the architectural register-file write port of the two copies in every running cycle (enable, destination index and write data) and records the cycle of the first disagreement. Speculative state never reaches this port, so it takes no part in the comparison. If one copy finishes and the other does not finish within a parameterised number of cycles, the run ends with a timeout, which also counts as a leak.

A single-cycle `start` pulse clears all state and begins a run. Cycle numbering starts at 1 for the first clock cycle after the `start` cycle. The results are final when `result_valid` pulses, and they hold until the next `start`.

Top module: `lockstep_leak_monitor`

## Requirements
- R1: While `rst_n` is low, and after its release until the first `start`, every output is 0.
- R2: In the cycle after a `start` pulse, both counts, both done flags, `leak`, `timeout`, `rf_mismatch` and `rf_mismatch_cycle` are 0 and `busy` is 1. Inputs sampled in the `start` cycle itself are ignored.
- R3: A copy's count equals the number of the cycle in which its tohost input is first high, counting that cycle. Its done flag rises at that edge. Later tohost pulses from that copy leave the count and the flag unchanged.
- R4: When both copies have finished, `result_valid` is high for exactly the one cycle after the later termination cycle. `leak` is 1 exactly when the two counts differ, and `timeout` is 0.
- R5: When one copy has finished and the other shows no tohost during the next TIMEOUT cycles, the run ends at the last of those cycles. `timeout` and `leak` become 1, and the unfinished copy's count equals the number of that last cycle. `result_valid` pulses one cycle later.
- R6: A tohost from the unfinished copy in the last cycle of the timeout window is a normal termination. No timeout is raised.
- R7: A running cycle is a mismatch when the two write enables differ, or when both are 1 and either the destination or the data differ. When both enables are 0, destination and data are ignored.
- R8: `rf_mismatch` is set by the first mismatch of a run and stays set. `rf_mismatch_cycle` latches that cycle's number, and later mismatches do not change it. Cycles after the final termination or timeout are not compared.
- R9: `result_valid` is never high for two cycles in a row. `leak`, `timeout` and both counts hold until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with both core copies |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse: clear and begin a run |
| a_tohost | input | 1 | Copy A stores to its tohost flag this cycle |
| b_tohost | input | 1 | Copy B stores to its tohost flag this cycle |
| a_rf_we | input | 1 | Copy A architectural register write enable |
| a_rf_dst | input | ADDR_W | Copy A destination register index |
| a_rf_data | input | DATA_W | Copy A write data |
| b_rf_we | input | 1 | Copy B architectural register write enable |
| b_rf_dst | input | ADDR_W | Copy B destination register index |
| b_rf_data | input | DATA_W | Copy B write data |
| busy | output | 1 | A run is in progress and not yet finalised |
| a_done | output | 1 | Copy A has terminated |
| b_done | output | 1 | Copy B has terminated |
| a_cycles | output | CNT_W | Copy A cycle count |
| b_cycles | output | CNT_W | Copy B cycle count |
| result_valid | output | 1 | One-cycle pulse: results are final |
| leak | output | 1 | Counts differ, or timeout |
| timeout | output | 1 | Second copy failed to finish in time |
| rf_mismatch | output | 1 | Sticky register-write divergence flag |
| rf_mismatch_cycle | output | CNT_W | Cycle number of the first divergence |

## Verification
The case that needs care is the unfinished copy's termination arriving in the same cycle that the timeout window expires. The bench schedules the second tohost exactly TIMEOUT cycles after the first one, and again one cycle later. It expects a clean termination with equal-rule leak evaluation in the first case and a timeout in the second. It also places a register-write divergence in the very cycle of the final termination, and one cycle after it. The first must be logged and the second must not, which tests that the comparison window closes on the same edge as the run.

// File: rtl/lsm_pkg.sv
// Package: shared types for the lockstep leak monitor.
// Assumes: nothing beyond standard SystemVerilog.
package lsm_pkg;
    // Run state of the monitor.
    typedef enum logic [1:0] {
        MON_IDLE = 2'd0,
        MON_RUN  = 2'd1,
        MON_DONE = 2'd2
    } mon_state_e;
endpackage

// File: rtl/lsm_lane_timer.sv
// Module: per-copy cycle counter with termination latch.
// Counts every running cycle until the copy's tohost store is seen, counts
// that cycle too, then freezes. Assumes clear has priority over run.
module lsm_lane_timer #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             tohost,
    output logic             done,
    output logic [CNT_W-1:0] count
);
    // Advance the count while running and latch termination.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            done  <= 1'b0;
            count <= '0;
        end else if (run && !done) begin
            count <= count + 1'b1;
            if (tohost) begin
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/lsm_rf_compare.sv
// Module: register-file write-port comparator.
// Numbers running cycles from 1, flags the first divergence between the two
// write ports and latches its cycle number. Assumes enables are exact (no X).
module lsm_rf_compare #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_dst,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_dst,
    input  logic [DATA_W-1:0] b_data,
    output logic              mismatch,
    output logic [CNT_W-1:0]  mismatch_cycle
);
    logic [CNT_W-1:0] cyc_q;
    logic             differ;

    // A write differs if enables disagree or an active write disagrees in target or value.
    always_comb begin
        differ = (a_we != b_we) || (a_we && ((a_dst != b_dst) || (a_data != b_data)));
    end

    // Running cycle counter used to stamp the first divergence.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cyc_q <= '0;
        end else if (run) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Sticky divergence flag and first-divergence cycle stamp.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mismatch       <= 1'b0;
            mismatch_cycle <= '0;
        end else if (run && differ && !mismatch) begin
            mismatch       <= 1'b1;
            mismatch_cycle <= cyc_q + 1'b1;
        end
    end
endmodule

// File: rtl/lsm_timeout.sv
// Module: straggler timeout.
// Once exactly one copy has terminated, counts cycles in which the other copy
// shows no tohost; expires on the TIMEOUT-th such cycle. A tohost in that
// final cycle wins over expiry. Assumes TIMEOUT >= 1.
module lsm_timeout #(
    parameter int TIMEOUT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic a_done,
    input  logic b_done,
    input  logic a_tohost,
    input  logic b_tohost,
    output logic expired
);
    localparam int TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

    logic [TW-1:0] wait_q;
    logic          waiting;
    logic          late_arrival;

    // One copy finished; check whether the other finishes now.
    always_comb begin
        waiting      = a_done ^ b_done;
        late_arrival = a_done ? b_tohost : a_tohost;
    end

    // Window counter and expiry flag.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wait_q  <= '0;
            expired <= 1'b0;
        end else if (run && waiting && !late_arrival) begin
            if (wait_q == LAST) begin
                expired <= 1'b1;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lockstep_leak_monitor.sv
// Module: top of the lockstep timing leak monitor.
// Runs one counter per core copy, a register-write comparator and a straggler
// timeout, then finalises a leak verdict one cycle after the run ends.
// Assumes both copies share clk and rst_n and start is a one-cycle pulse.
module lockstep_leak_monitor
    import lsm_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 64,
    parameter int TIMEOUT = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              a_tohost,
    input  logic              b_tohost,
    input  logic              a_rf_we,
    input  logic [ADDR_W-1:0] a_rf_dst,
    input  logic [DATA_W-1:0] a_rf_data,
    input  logic              b_rf_we,
    input  logic [ADDR_W-1:0] b_rf_dst,
    input  logic [DATA_W-1:0] b_rf_data,
    output logic              busy,
    output logic              a_done,
    output logic              b_done,
    output logic [CNT_W-1:0]  a_cycles,
    output logic [CNT_W-1:0]  b_cycles,
    output logic              result_valid,
    output logic              leak,
    output logic              timeout,
    output logic              rf_mismatch,
    output logic [CNT_W-1:0]  rf_mismatch_cycle
);
    localparam int LANES = 2;

    mon_state_e             state_q;
    logic                   running;
    logic                   run_over;
    logic [LANES-1:0]       lane_th;
    logic [LANES-1:0]       lane_done;
    logic [CNT_W-1:0]       lane_cnt [LANES];

    assign lane_th = {b_tohost, a_tohost};

    // Run is live until both copies ended or the straggler timed out.
    always_comb begin
        run_over = (&lane_done) || timeout;
        running  = (state_q == MON_RUN) && !run_over;
    end

    // One cycle counter per core copy.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lsm_lane_timer #(.CNT_W(CNT_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (start),
            .run    (running),
            .tohost (lane_th[g]),
            .done   (lane_done[g]),
            .count  (lane_cnt[g])
        );
    end

    lsm_rf_compare #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear          (start),
        .run            (running),
        .a_we           (a_rf_we),
        .a_dst          (a_rf_dst),
        .a_data         (a_rf_data),
        .b_we           (b_rf_we),
        .b_dst          (b_rf_dst),
        .b_data         (b_rf_data),
        .mismatch       (rf_mismatch),
        .mismatch_cycle (rf_mismatch_cycle)
    );

    lsm_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .run      (running),
        .a_done   (lane_done[0]),
        .b_done   (lane_done[1]),
        .a_tohost (a_tohost),
        .b_tohost (b_tohost),
        .expired  (timeout)
    );

    // Run state, verdict and result pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= MON_IDLE;
            leak         <= 1'b0;
            result_valid <= 1'b0;
        end else if (start) begin
            state_q      <= MON_RUN;
            leak         <= 1'b0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (state_q == MON_RUN && run_over) begin
                leak         <= timeout || (lane_cnt[0] != lane_cnt[1]);
                result_valid <= 1'b1;
                state_q      <= MON_DONE;
            end
        end
    end

    assign busy     = (state_q == MON_RUN);
    assign a_done   = lane_done[0];
    assign b_done   = lane_done[1];
    assign a_cycles = lane_cnt[0];
    assign b_cycles = lane_cnt[1];
endmodule

// File: rtl/lsm_checker.sv
// Module: assertion checker for the lockstep leak monitor, bound to the top.
// Assumes the same parameters as the monitor instance it is bound to.
module lsm_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             a_done,
    input logic             b_done,
    input logic [CNT_W-1:0] a_cycles,
    input logic [CNT_W-1:0] b_cycles,
    input logic             result_valid,
    input logic             leak,
    input logic             timeout,
    input logic             rf_mismatch,
    input logic [CNT_W-1:0] rf_mismatch_cycle
);
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (a_cycles == '0 && b_cycles == '0 && !a_done && !b_done && !leak && !timeout && !rf_mismatch)); // R2
    AST_A_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (a_done && !start) |=> (a_done && $stable(a_cycles))); // R3
    AST_B_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (b_done && !start) |=> (b_done && $stable(b_cycles))); // R3
    AST_LEAK_FROM_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !timeout) |-> (leak == (a_cycles != b_cycles))); // R4
    AST_TIMEOUT_LEAKS: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && timeout) |-> leak); // R5
    AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_mismatch && !start) |=> (rf_mismatch && $stable(rf_mismatch_cycle))); // R8
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid); // R9
    AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !start) |=> ($stable(leak) && $stable(timeout))); // R9
endmodule

bind lockstep_leak_monitor lsm_checker #(.CNT_W(CNT_W)) u_lsm_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .start             (start),
    .a_done            (a_done),
    .b_done            (b_done),
    .a_cycles          (a_cycles),
    .b_cycles          (b_cycles),
    .result_valid      (result_valid),
    .leak              (leak),
    .timeout           (timeout),
    .rf_mismatch       (rf_mismatch),
    .rf_mismatch_cycle (rf_mismatch_cycle)
);

// File: tb/lockstep_leak_monitor_test.sv
module lockstep_leak_monitor_test;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 64;
    localparam int TMO    = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              a_tohost = 1'b0, b_tohost = 1'b0;
    logic              a_rf_we = 1'b0, b_rf_we = 1'b0;
    logic [ADDR_W-1:0] a_rf_dst = '0, b_rf_dst = '0;
    logic [DATA_W-1:0] a_rf_data = '0, b_rf_data = '0;
    logic              busy, a_done, b_done, result_valid, leak, timeout, rf_mismatch;
    logic [CNT_W-1:0]  a_cycles, b_cycles, rf_mismatch_cycle;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    lockstep_leak_monitor #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .a_tohost(a_tohost), .b_tohost(b_tohost),
        .a_rf_we(a_rf_we), .a_rf_dst(a_rf_dst), .a_rf_data(a_rf_data),
        .b_rf_we(b_rf_we), .b_rf_dst(b_rf_dst), .b_rf_data(b_rf_data),
        .busy(busy), .a_done(a_done), .b_done(b_done),
        .a_cycles(a_cycles), .b_cycles(b_cycles),
        .result_valid(result_valid), .leak(leak), .timeout(timeout),
        .rf_mismatch(rf_mismatch), .rf_mismatch_cycle(rf_mismatch_cycle)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    // ka/kb: termination cycle of each copy, 0 = never. mm1/mm2: divergence cycles, 0 = none.
    task automatic trial(input int ka, input int kb, input int mm1, input int mm2);
        int  end_c, first, exp_ca, exp_cb, exp_mm, seen;
        bit  exp_tmo, exp_leak;
        // Model of the requirements (R3, R4, R5, R6).
        if (ka > 0 && kb > 0 && (ka - kb <= TMO) && (kb - ka <= TMO)) begin
            end_c = imax(ka, kb); exp_tmo = 1'b0;
            exp_ca = ka; exp_cb = kb; exp_leak = (ka != kb);
        end else begin
            if (ka == 0) first = kb;
            else if (kb == 0) first = ka;
            else first = (ka < kb) ? ka : kb;
            end_c = first + TMO; exp_tmo = 1'b1; exp_leak = 1'b1;
            exp_ca = (ka == first) ? ka : end_c;
            exp_cb = (kb == first && ka != first) ? kb : end_c;
        end
        // Model of R7/R8: first divergence inside the run window.
        exp_mm = 0;
        if (mm1 > 0 && mm1 <= end_c) exp_mm = mm1;
        else if (mm2 > 0 && mm2 <= end_c) exp_mm = mm2;
        if (mm1 > 0 && mm2 > 0 && mm2 <= end_c && mm1 <= end_c) exp_mm = (mm1 < mm2) ? mm1 : mm2;

        @(negedge clk);
        start = 1'b1; a_tohost = 1'b1; b_tohost = 1'b0;
        a_rf_we = 1'b1; b_rf_we = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(a_cycles == 0 && b_cycles == 0 && !a_done && !b_done, "R2", "counts/done after start",
            a_cycles + b_cycles, 0);
        chk(!leak && !timeout && !rf_mismatch && busy, "R2", "flags after start",
            {leak, timeout, rf_mismatch, busy}, 1);
        seen = 0;
        for (int c = 1; c <= end_c + 3; c++) begin
            bit we;
            we        = 1'($urandom % 2);
            a_rf_we   = we; b_rf_we = we;
            a_rf_dst  = ADDR_W'($urandom); b_rf_dst = a_rf_dst;
            a_rf_data = {$urandom, $urandom}; b_rf_data = a_rf_data;
            if (!we) begin
                b_rf_dst  = ADDR_W'($urandom);      // ignored per R7
                b_rf_data = {$urandom, $urandom};
            end
            if (c == mm1 || c == mm2) begin
                case ($urandom % 3)
                    0: b_rf_we = ~a_rf_we;
                    1: begin a_rf_we = 1'b1; b_rf_we = 1'b1; b_rf_dst = a_rf_dst ^ 5'd1; end
                    default: begin a_rf_we = 1'b1; b_rf_we = 1'b1; b_rf_dst = a_rf_dst;
                                   b_rf_data = a_rf_data ^ 64'd1; end
                endcase
            end
            a_tohost = (c == ka) || (ka > 0 && c > ka && ($urandom % 4 == 0));
            b_tohost = (c == kb) || (kb > 0 && c > kb && ($urandom % 4 == 0));
            @(negedge clk);
            if (result_valid) begin
                seen = c;
                break;
            end
        end
        chk(seen == end_c + 1, exp_tmo ? "R5" : "R4", "result_valid cycle", seen, end_c + 1);
        chk(a_cycles == exp_ca, "R3", "copy A count", a_cycles, exp_ca);
        chk(b_cycles == exp_cb, exp_tmo ? "R5" : "R3", "copy B count", b_cycles, exp_cb);
        chk(leak == exp_leak, exp_tmo ? "R5" : "R4", "leak", leak, exp_leak);
        chk(timeout == exp_tmo, (ka > 0 && kb > 0 && (ka - kb == TMO || kb - ka == TMO)) ? "R6" : "R5",
            "timeout", timeout, exp_tmo);
        chk(rf_mismatch == (exp_mm != 0), "R7", "mismatch flag", rf_mismatch, exp_mm != 0);
        chk(rf_mismatch_cycle == exp_mm, "R8", "mismatch cycle", rf_mismatch_cycle, exp_mm);
        a_tohost = 1'b1; b_tohost = 1'b1; a_rf_we = 1'b1; b_rf_we = 1'b0;
        @(negedge clk);
        chk(!result_valid, "R9", "result_valid pulse width", result_valid, 0);
        chk(leak == exp_leak && a_cycles == exp_ca && b_cycles == exp_cb && timeout == exp_tmo,
            "R9", "results hold", leak, exp_leak);
        chk(rf_mismatch_cycle == exp_mm, "R8", "mismatch cycle after run", rf_mismatch_cycle, exp_mm);
        a_tohost = 1'b0; b_tohost = 1'b0; a_rf_we = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        repeat (3) @(negedge clk);
        chk(!busy && !result_valid && !leak && !timeout && !rf_mismatch && !a_done && !b_done,
            "R1", "outputs in reset", {busy, leak, timeout, rf_mismatch}, 0);
        rst_n = 1'b1;
        a_tohost = 1'b1; a_rf_we = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && a_cycles == 0 && !a_done && !rf_mismatch, "R1", "idle before start", a_cycles, 0);
        a_tohost = 1'b0; a_rf_we = 1'b0;

        trial(5, 5, 0, 0);            // R4 equal counts
        trial(5, 9, 3, 7);            // R4 leak, R8 first of two
        trial(9, 5, 0, 0);            // R4 leak, other order
        trial(1, 1, 1, 0);            // first-cycle termination and divergence
        trial(3, 0, 0, 0);            // R5 B never finishes
        trial(0, 4, 10, 0);           // R5 A never finishes
        trial(4, 4 + TMO, 0, 0);      // R6 arrival on last window cycle
        trial(4, 5 + TMO, 0, 0);      // R5 one cycle too late
        trial(6, 8, 8, 0);            // R8 divergence on final cycle counts
        trial(6, 8, 9, 0);            // R8 divergence after run ignored
        for (int t = 0; t < 60; t++) begin
            int ka, kb, m1, m2;
            ka = 1 + int'($urandom % 40);
            kb = ($urandom % 5 == 0) ? 0 : 1 + int'($urandom % 40);
            if ($urandom % 2 == 0) kb = ka;
            m1 = ($urandom % 3 == 0) ? 0 : 1 + int'($urandom % 50);
            m2 = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 50);
            trial(ka, kb, m1, m2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule